// File: doc/BRIEF.md
# PCIe Configuration Window Decoder

This block holds the 64-bit base-address register that places the memory-mapped PCIe configuration space in the system address map. It decodes that register into a window. Software writes the register through a byte-enabled configuration write port and reads it back through a simple read port. The decode gives a window enable, an aligned window base, and a window length in bytes. A probe port compares an incoming 64-bit address against the window and reports a hit. The block also gives the start of the 32-bit PCI memory hole, which begins just past the window.

The register holds three fields: an enable bit, a two-bit size code and a base field. The size code sets both the window length and how many base bits take part in the alignment, so a smaller window can be placed on a finer boundary. One size code is reserved. It turns the window off completely. The decoded results are registered. They change only on a clock edge that captures a configuration write overlapping the register, or on reset.

Top module: `cfgwin_decoder`

## Requirements
- R1: The window is enabled (`win_en` = 1) only when register bit 0 is set and the size code is not reserved.
- R2: Register bits [2:1] hold the size code. Code 00 gives `win_len` = 0x1000_0000 (256 MB), code 01 gives 0x0800_0000 (128 MB) and code 10 gives 0x0400_0000 (64 MB). `win_len` reports the decoded size even while bit 0 is clear.
- R3: Size code 11 is reserved. It forces `win_en` = 0, `win_len` = 0 and `win_base` = 0, and `probe_hit` never asserts.
- R4: The base field is register bits [35:26]. `win_base` keeps bits [35:28] for 256 MB, bits [35:27] for 128 MB and bits [35:26] for 64 MB. All other bits of `win_base` are zero.
- R5: `probe_hit` is registered. It is 1 in the cycle after `probe_valid` is high when the window is enabled and every bit of `probe_addr` at or above log2(`win_len`) equals the same bit of `win_base`. Otherwise it is 0.
- R6: `hole_start` equals the low 32 bits of `win_base + win_len` while the window is enabled. Otherwise it equals the default base 0xB000_0000.
- R7: Reset loads the register with the default base 0xB000_0000, with bit 0 = 0 and size code 00. The outputs then decode that value: `win_en` = 0, `win_len` = 256 MB, `win_base` = `hole_start` = 0xB000_0000.
- R8: The register occupies two 32-bit configuration words. Word 0x18 holds bits [31:0] and word 0x19 holds bits [63:32]. A write changes only the byte lanes whose `cfg_be` bit is set. Bits outside the three fields always read 0. Writes to other words, and writes with no byte enable, leave the register unchanged.
- R9: The decoded outputs update on the clock edge that captures an overlapping write and are visible in the following cycle. At all other times they hold.
- R10: `cfg_rdata` returns the addressed register word one cycle after `cfg_raddr` is applied. Any other word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 8 | Configuration write word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_raddr | input | 8 | Configuration read word address |
| cfg_rdata | output | 32 | Read data, one cycle after the address |
| probe_valid | input | 1 | Probe address is valid |
| probe_addr | input | 64 | Address to compare against the window |
| probe_hit | output | 1 | Registered window hit for the probe |
| win_en | output | 1 | Window is enabled |
| win_base | output | 64 | Aligned window base |
| win_len | output | 32 | Window length in bytes |
| hole_start | output | 32 | Start of the 32-bit PCI memory hole |

## Verification
A wrong register value, such as a byte lane merged from the wrong data lane or a field bit that fails to clear, shows up in two places. The register word read back one cycle later is wrong, and so are the decoded outputs sampled one cycle after the write. A wrong mask or a wrong size decode makes `win_base`, `win_len` and `hole_start` disagree with the bench model right after the write. It also causes false hits or misses for probes placed just inside or just outside the window boundary, which appear in the next cycle. Stale decoded state after a write shows up at the first check that follows that write.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

  localparam int EN_BIT  = 0;
  localparam int SZ_LO   = 1;
  localparam int SZ_HI   = 2;
  localparam int BASE_LO = 26;
  localparam int BASE_HI = 35;

  typedef enum logic [1:0] {
    SZ_256M = 2'b00,
    SZ_128M = 2'b01,
    SZ_64M  = 2'b10,
    SZ_RSVD = 2'b11
  } size_code_e;

  // log2 of the window length in bytes; 0 marks the reserved code
  function automatic int unsigned size_log2(size_code_e code);
    case (code)
      SZ_256M: return 28;
      SZ_128M: return 27;
      SZ_64M:  return 26;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cfgwin_regfile.sv
module cfgwin_regfile
  import cfgwin_pkg::*;
#(
  parameter int                CFG_AW    = 8,
  parameter int                CFG_DW    = 32,
  parameter int                REG_W     = 64,
  parameter int unsigned       REG_WORD  = 8'h18,
  parameter logic [REG_W-1:0]  RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic [CFG_DW/8-1:0] cfg_be,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic [REG_W-1:0]  reg_next,
  output logic              reg_upd
);

  localparam int LANES_PER_WORD = CFG_DW / 8;
  localparam int WORDS          = REG_W / CFG_DW;
  localparam int REG_LANES      = REG_W / 8;
  localparam logic [REG_W-1:0] FIELD_MASK =
      (({REG_W{1'b1}} >> (REG_W - BASE_HI - 1)) & ({REG_W{1'b1}} << BASE_LO))
      | REG_W'(1 << EN_BIT) | REG_W'(3 << SZ_LO);

  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] merged;
  logic [WORDS-1:0] word_sel;
  logic [CFG_DW-1:0] rd_mux [WORDS+1];

  // one select per configuration word covered by the register
  for (genvar w = 0; w < WORDS; w++) begin : g_wsel
    assign word_sel[w] = cfg_we && (cfg_waddr == CFG_AW'(REG_WORD + w));
  end

  // byte-lane merge of the incoming write data
  for (genvar b = 0; b < REG_LANES; b++) begin : g_lane
    localparam int WI = b / LANES_PER_WORD;
    localparam int LI = b % LANES_PER_WORD;
    logic take;
    assign take = word_sel[WI] && cfg_be[LI];
    assign merged[b*8 +: 8] = take ? cfg_wdata[LI*8 +: 8] : reg_q[b*8 +: 8];
  end

  assign reg_upd  = (|word_sel) && (|cfg_be);
  assign reg_next = merged & FIELD_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= RESET_VAL & FIELD_MASK;
    end else if (reg_upd) begin
      reg_q <= reg_next;
    end
  end

  // read mux chain over the register words
  assign rd_mux[0] = '0;
  for (genvar w = 0; w < WORDS; w++) begin : g_rd
    assign rd_mux[w+1] = (cfg_raddr == CFG_AW'(REG_WORD + w))
                         ? reg_q[w*CFG_DW +: CFG_DW] : rd_mux[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= rd_mux[WORDS];
    end
  end

  // R8: the register moves only on an overlapping write
  a_r8_reg_holds: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_upd) && !$past(rst)) |-> $stable(reg_q));

  // R8: bits outside the fields never become set
  a_r8_fields_only: assert property (@(posedge clk) disable iff (rst)
    (reg_q & ~FIELD_MASK) == '0);

endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int                REG_W     = 64,
  parameter int                LEN_W     = 32,
  parameter int                HOLE_W    = 32,
  parameter logic [REG_W-1:0]  RESET_VAL = 64'h0000_0000_B000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  reg_next,
  input  logic              reg_upd,
  output logic              en_q,
  output logic [REG_W-1:0]  mask_q,
  output logic [REG_W-1:0]  base_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [HOLE_W-1:0] hole_q
);

  localparam logic [HOLE_W-1:0] HOLE_DEFAULT = RESET_VAL[HOLE_W-1:0];

  logic [REG_W-1:0]  src;
  size_code_e        code;
  int unsigned       lg;
  logic              valid;
  logic              en_d;
  logic [LEN_W-1:0]  len_d;
  logic [REG_W-1:0]  mask_d;
  logic [REG_W-1:0]  base_d;
  logic [HOLE_W-1:0] hole_d;

  // reset writes the default value, then the same decode runs on it
  assign src   = rst ? RESET_VAL : reg_next;
  assign code  = size_code_e'(src[SZ_HI:SZ_LO]);
  assign lg    = size_log2(code);
  assign valid = (code != SZ_RSVD);

  always_comb begin
    en_d   = src[EN_BIT] && valid;
    len_d  = valid ? (LEN_W'(1) << lg) : '0;
    mask_d = valid ? ({REG_W{1'b1}} << lg) : '0;
    base_d = src & mask_d;
    hole_d = en_d ? (base_d[HOLE_W-1:0] + HOLE_W'(len_d)) : HOLE_DEFAULT;
  end

  always_ff @(posedge clk) begin
    if (rst || reg_upd) begin
      en_q   <= en_d;
      len_q  <= len_d;
      mask_q <= mask_d;
      base_q <= base_d;
      hole_q <= hole_d;
    end
  end

  // R9: decoded state holds unless a write overlapped the register
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_upd) && !$past(rst)) |->
      ($stable(en_q) && $stable(base_q) && $stable(len_q) && $stable(hole_q)));

  // R2: a decoded length is a single power of two or zero
  a_r2_len_pow2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(len_q));

endmodule

// File: rtl/cfgwin_match.sv
module cfgwin_match #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              en,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] base,
  output logic              hit_q
);

  logic in_window;

  assign in_window = en && ((probe_addr & mask) == base);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= probe_valid && in_window;
    end
  end

  // R5: a hit only follows a valid probe
  a_r5_hit_needs_probe: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(probe_valid));

endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder #(
  parameter int               CFG_AW      = 8,
  parameter int               CFG_DW      = 32,
  parameter int               ADDR_W      = 64,
  parameter int               LEN_W       = 32,
  parameter int               HOLE_W      = 32,
  parameter int unsigned      REG_WORD    = 8'h18,
  parameter logic [ADDR_W-1:0] DEFAULT_BASE = 64'h0000_0000_B000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_waddr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic [CFG_DW/8-1:0] cfg_be,
  input  logic [CFG_AW-1:0]   cfg_raddr,
  output logic [CFG_DW-1:0]   cfg_rdata,
  input  logic                probe_valid,
  input  logic [ADDR_W-1:0]   probe_addr,
  output logic                probe_hit,
  output logic                win_en,
  output logic [ADDR_W-1:0]   win_base,
  output logic [LEN_W-1:0]    win_len,
  output logic [HOLE_W-1:0]   hole_start
);

  logic [ADDR_W-1:0] reg_next;
  logic              reg_upd;
  logic [ADDR_W-1:0] win_mask;

  cfgwin_regfile #(
    .CFG_AW   (CFG_AW),
    .CFG_DW   (CFG_DW),
    .REG_W    (ADDR_W),
    .REG_WORD (REG_WORD),
    .RESET_VAL(DEFAULT_BASE)
  ) u_regfile (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata),
    .cfg_be   (cfg_be),
    .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata),
    .reg_next (reg_next),
    .reg_upd  (reg_upd)
  );

  cfgwin_decode #(
    .REG_W    (ADDR_W),
    .LEN_W    (LEN_W),
    .HOLE_W   (HOLE_W),
    .RESET_VAL(DEFAULT_BASE)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .reg_next(reg_next),
    .reg_upd (reg_upd),
    .en_q    (win_en),
    .mask_q  (win_mask),
    .base_q  (win_base),
    .len_q   (win_len),
    .hole_q  (hole_start)
  );

  cfgwin_match #(
    .ADDR_W(ADDR_W)
  ) u_match (
    .clk        (clk),
    .rst        (rst),
    .probe_valid(probe_valid),
    .probe_addr (probe_addr),
    .en         (win_en),
    .mask       (win_mask),
    .base       (win_base),
    .hit_q      (probe_hit)
  );

  // R3: no hit unless the window was enabled at the sampling edge
  a_r3_hit_needs_enable: assert property (@(posedge clk) disable iff (rst)
    probe_hit |-> $past(win_en));

  // R1: an enabled window always has a length
  a_r1_enable_has_len: assert property (@(posedge clk) disable iff (rst)
    win_en |-> (win_len != '0));

  // R4: the base is aligned to the window length
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (rst)
    (win_base & (ADDR_W'(win_len) - ADDR_W'(1))) == '0);

  // R7: right after reset the window is off and the hole sits at the default
  a_r7_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!win_en && hole_start == DEFAULT_BASE[HOLE_W-1:0]));

endmodule

// File: tb/cfgwin_decoder_tb.sv
module cfgwin_decoder_tb;

  localparam logic [63:0] DEF_BASE = 64'h0000_0000_B000_0000;
  localparam logic [63:0] FMASK    = 64'h0000_000F_FC00_0007;
  localparam logic [7:0]  WLO      = 8'h18;
  localparam logic [7:0]  WHI      = 8'h19;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_waddr;
  logic [31:0] cfg_wdata;
  logic [3:0]  cfg_be;
  logic [7:0]  cfg_raddr;
  logic [31:0] cfg_rdata;
  logic        probe_valid;
  logic [63:0] probe_addr;
  logic        probe_hit;
  logic        win_en;
  logic [63:0] win_base;
  logic [31:0] win_len;
  logic [31:0] hole_start;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [63:0] model;

  always #5 clk = ~clk;

  cfgwin_decoder u_dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_be(cfg_be),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .win_en(win_en), .win_base(win_base), .win_len(win_len), .hole_start(hole_start)
  );

  function automatic int exp_lg(logic [63:0] r);
    case (r[2:1])
      2'b00:   return 28;
      2'b01:   return 27;
      2'b10:   return 26;
      default: return -1;
    endcase
  endfunction

  function automatic logic exp_en(logic [63:0] r);
    return r[0] && (exp_lg(r) >= 0);
  endfunction

  function automatic logic [31:0] exp_len(logic [63:0] r);
    if (exp_lg(r) < 0) return 32'h0;
    return 32'h1 << exp_lg(r);
  endfunction

  function automatic logic [63:0] exp_base(logic [63:0] r);
    if (exp_lg(r) < 0) return 64'h0;
    return (r >> exp_lg(r)) << exp_lg(r);
  endfunction

  function automatic logic [31:0] exp_hole(logic [63:0] r);
    logic [63:0] s;
    if (!exp_en(r)) return DEF_BASE[31:0];
    s = exp_base(r) + 64'(exp_len(r));
    return s[31:0];
  endfunction

  function automatic logic exp_hit(logic [63:0] r, logic [63:0] a);
    if (!exp_en(r)) return 1'b0;
    return (a >> exp_lg(r)) == (exp_base(r) >> exp_lg(r));
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    chk(win_en === exp_en(model), {"R1 win_en ", tag}, 64'(win_en), 64'(exp_en(model)));
    chk(win_len === exp_len(model), {"R2 win_len ", tag}, 64'(win_len), 64'(exp_len(model)));
    chk(win_base === exp_base(model), {"R4 win_base ", tag}, win_base, exp_base(model));
    chk(hole_start === exp_hole(model), {"R6 hole_start ", tag}, 64'(hole_start),
        64'(exp_hole(model)));
  endtask

  // write then check decoded outputs one cycle after the capturing edge (R9)
  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d; cfg_be = be;
    for (int i = 0; i < 4; i++) begin
      if (be[i] && a == WLO) model[i*8 +: 8] = d[i*8 +: 8];
      if (be[i] && a == WHI) model[32 + i*8 +: 8] = d[i*8 +: 8];
    end
    model = model & FMASK;
    @(negedge clk);
    cfg_we = 1'b0;
    check_outputs("R9 after write");
  endtask

  task automatic cfg_read(input logic [7:0] a);
    logic [31:0] e;
    e = (a == WLO) ? model[31:0] : (a == WHI) ? model[63:32] : 32'h0;
    cfg_raddr = a;
    @(negedge clk);
    chk(cfg_rdata === e, "R10/R8 readback", 64'(cfg_rdata), 64'(e));
  endtask

  task automatic probe(input logic [63:0] a, input string req);
    logic e;
    e = exp_hit(model, a);
    probe_valid = 1'b1; probe_addr = a;
    @(negedge clk);
    probe_valid = 1'b0;
    chk(probe_hit === e, req, 64'(probe_hit), 64'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; cfg_we = 1'b0; cfg_waddr = '0; cfg_wdata = '0; cfg_be = '0;
    cfg_raddr = '0; probe_valid = 1'b0; probe_addr = '0;
    model = DEF_BASE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R7 reset state
    check_outputs("R7 reset");
    cfg_read(WLO);
    cfg_read(WHI);
    probe(DEF_BASE, "R5 disabled window no hit");

    // R1/R2 256 MB enabled at default base
    cfg_write(WLO, 32'hB000_0001, 4'hF);
    probe(64'hB000_0000, "R5 hit at base");
    probe(64'hBFFF_FFFF, "R5 hit at last byte");
    probe(64'hC000_0000, "R5 miss past end");
    probe(64'h1_B000_0000, "R5 miss upper bits");
    probe_valid = 1'b0; probe_addr = 64'hB000_0000;
    @(negedge clk);
    chk(probe_hit === 1'b0, "R5 no hit without valid", 64'(probe_hit), 64'h0);

    // R4 128 MB keeps bit 27, 64 MB keeps bit 26
    cfg_write(WLO, 32'hEC00_0003, 4'hF);
    probe(64'hE800_0000, "R5 128MB hit");
    probe(64'hF000_0000, "R5 128MB miss");
    cfg_write(WLO, 32'hEC00_0005, 4'h1);
    probe(64'hEC00_0000, "R5 64MB hit");
    probe(64'hE800_0000, "R5 64MB miss");

    // R3 reserved code
    cfg_write(WLO, 32'h0000_0007, 4'h1);
    probe(64'hEC00_0000, "R3 reserved no hit");

    // R8 upper word partial bytes, hole wraps low 32 bits (R6)
    cfg_write(WLO, 32'hFC00_0001, 4'hF);
    cfg_write(WHI, 32'hFFFF_FF05, 4'h1);
    cfg_read(WHI);
    probe(64'h5_FC00_0000, "R5 hit above 4G");
    // R8 ignored writes
    cfg_write(8'h17, 32'h0, 4'hF);
    cfg_write(WLO, 32'h0, 4'h0);
    cfg_read(WLO);
    cfg_read(8'h1A);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [7:0] a;
      logic [63:0] pa;
      a = 8'h17 + 8'($urandom % 4);
      cfg_write(a, $urandom, 4'($urandom));
      if (it % 3 == 0) cfg_read(WLO + 8'($urandom % 2));
      for (int p = 0; p < 3; p++) begin
        if (exp_len(model) != 0 && ($urandom % 4) != 0)
          pa = exp_base(model) + 64'($urandom % (2 * exp_len(model)));
        else
          pa = {28'h0, 4'($urandom), $urandom};
        probe(pa, "R5 random probe");
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule